// File: doc/BRIEF.md
# Two-Level Interrupt Register Block

This block sits between a peripheral core and a simple word-addressed register bus and turns the core's interrupt events into one interrupt line. Events from the core arrive as one-cycle pulses. Each pulse latches into a bit of an IP-level status register, and a matching IP-level enable register masks those bits. All enabled IP status bits are ORed into a single bit of a device-level status word. The other bits of that word come straight from level sources elsewhere in the device. A device-level enable masks the device word, and a global enable gates the final interrupt output.

Software acknowledges an IP status bit by writing a 1 to it. Writing a 1 to a bit that is clear sets it, so the same write can both force a bit and acknowledge it. The core supplies the value that the IP status bits take at reset. A write of a key value to the reset register returns every register to its reset state. That state includes the global enable being off.

The number of implemented IP bits is set by a parameter from 0 to 32. Implemented bits start at bit 0, and all bits above them are tied to zero.

Top module: `irq_hier_regs`

## Requirements
- R1: On reset, the IP enable, device enable and global enable registers read 0. IP status reads `ipResetVal` masked to the implemented bits.
- R2: Writing the IP status register (word address 4) inverts every implemented bit written with 1. Bits written with 0 keep their value.
- R3: The IP enable register (word address 5) reads back exactly the last value written, limited to the implemented bits. Writing 0 disables every IP source.
- R4: Bits at or above `IpWidth` always read 0 in IP status and IP enable. Writes, events and reset values on those bits are ignored.
- R5: A one-cycle pulse on `ipEvent[i]` sets IP status bit i. The bit stays set until software toggles it.
- R6: If an event pulse and a toggling status write hit the same bit in the same cycle, the bit ends set.
- R7: The device status word (address 0) is read-only. Bit `IpDevBit` is the OR of (IP status AND IP enable), and every other bit j is `devLevel[j]`. `devLevel[IpDevBit]` and writes to address 0 have no effect.
- R8: `irq` equals the global enable AND the OR of (device status AND device enable, address 1). It changes in the same cycle as the register update that causes it.
- R9: The global enable (address 2) is a single read/write bit in bit 0.
- R10: Writing address 3 with `busWdata[3:0]` equal to `RstKey` (default 4'hA) reloads the R1 reset state at that clock edge. Any other value written there has no effect.
- R11: Read data is registered and appears in the cycle after the read is presented. Address 3, unmapped addresses and idle cycles return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | AddrW | Word address |
| busWdata | input | DataW | Write data |
| busRdata | output | DataW | Read data, one cycle after the read |
| ipEvent | input | DataW | Event pulses from the core, one per IP bit |
| ipResetVal | input | DataW | Reset value of the IP status bits, from the core |
| devLevel | input | DevWidth | Level sources for the other device-level bits |
| irq | output | 1 | Interrupt output |

## Verification
Two updates can land on one IP status bit in the same clock edge: a core event pulse that sets the bit, and a bus write that toggles it. The bench first sets a bit. It then drives an acknowledge write and an event pulse for that bit in the same cycle, and reads the bit back. The bit must still read 1, where the write alone would clear it. The checker asserts the same set-wins rule on every cycle in which an event pulse arrives.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    ADR_DEV_STAT = 3'd0,
    ADR_DEV_EN   = 3'd1,
    ADR_GIE      = 3'd2,
    ADR_SOFT_RST = 3'd3,
    ADR_IP_STAT  = 3'd4,
    ADR_IP_EN    = 3'd5,
    ADR_NONE     = 3'd7
  } regAddrE;

  typedef struct packed {
    logic    wrDevEn;
    logic    wrGie;
    logic    wrIpStat;
    logic    wrIpEn;
    logic    softRst;
    logic    rdEn;
    regAddrE rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int AddrW  = 3,
  parameter int KeyW   = 4,
  parameter logic [KeyW-1:0] RstKey = 4'hA
) (
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AddrW-1:0] busAddr,
  input  logic [KeyW-1:0]  keyNibble,
  output ctrlStrobeT       strobe
);

  localparam int SelW = 3;

  logic    inRange;
  regAddrE addrCode;
  logic    doWrite;
  logic    doRead;

  generate
    if (AddrW > SelW) begin : g_wide
      assign inRange = (busAddr[AddrW-1:SelW] == '0);
    end else begin : g_narrow
      assign inRange = 1'b1;
    end
  endgenerate

  assign addrCode = inRange ? regAddrE'(busAddr[SelW-1:0]) : ADR_NONE;
  assign doWrite  = busSel & busWr;
  assign doRead   = busSel & ~busWr;

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = addrCode;
    strobe.rdEn     = doRead;
    strobe.wrDevEn  = doWrite && (addrCode == ADR_DEV_EN);
    strobe.wrGie    = doWrite && (addrCode == ADR_GIE);
    strobe.wrIpStat = doWrite && (addrCode == ADR_IP_STAT);
    strobe.wrIpEn   = doWrite && (addrCode == ADR_IP_EN);
    strobe.softRst  = doWrite && (addrCode == ADR_SOFT_RST) && (keyNibble == RstKey);
  end

endmodule

// File: rtl/irq_dpath.sv
module irq_dpath
  import irq_pkg::*;
#(
  parameter int DataW    = 32,
  parameter int IpWidth  = 12,
  parameter int DevWidth = 4,
  parameter int IpDevBit = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobeT          strobe,
  input  logic [DataW-1:0]    busWdata,
  input  logic [DataW-1:0]    ipEvent,
  input  logic [DataW-1:0]    ipResetVal,
  input  logic [DevWidth-1:0] devLevel,
  output logic [DataW-1:0]    busRdata,
  output logic [DataW-1:0]    ipStatQ,
  output logic [DataW-1:0]    ipEnQ,
  output logic [DevWidth-1:0] devEnQ,
  output logic                gieQ,
  output logic                irq
);

  logic                clrAll;
  logic                ipAgg;
  logic [DevWidth-1:0] devStat;
  logic [DataW-1:0]    rdMux;

  assign clrAll = rst | strobe.softRst;

  // IP level: one storage cell per implemented bit, constant zero above
  for (genvar i = 0; i < DataW; i++) begin : g_ipBit
    if (i < IpWidth) begin : g_impl
      always_ff @(posedge clk) begin
        if (clrAll) begin
          ipStatQ[i] <= ipResetVal[i];
          ipEnQ[i]   <= 1'b0;
        end else begin
          ipStatQ[i] <= (ipStatQ[i] ^ (strobe.wrIpStat & busWdata[i])) | ipEvent[i];
          if (strobe.wrIpEn) ipEnQ[i] <= busWdata[i];
        end
      end
    end else begin : g_tie
      assign ipStatQ[i] = 1'b0;
      assign ipEnQ[i]   = 1'b0;
    end
  end

  assign ipAgg = |(ipStatQ & ipEnQ);

  // Device level: the IP aggregate owns one bit, the rest follow level inputs
  for (genvar j = 0; j < DevWidth; j++) begin : g_devBit
    if (j == IpDevBit) begin : g_ip
      assign devStat[j] = ipAgg;
    end else begin : g_lvl
      assign devStat[j] = devLevel[j];
    end
  end

  always_ff @(posedge clk) begin
    if (clrAll) begin
      devEnQ <= '0;
      gieQ   <= 1'b0;
    end else begin
      if (strobe.wrDevEn) devEnQ <= busWdata[DevWidth-1:0];
      if (strobe.wrGie)   gieQ   <= busWdata[0];
    end
  end

  assign irq = gieQ & |(devStat & devEnQ);

  always_comb begin
    case (strobe.rdSel)
      ADR_DEV_STAT: rdMux = DataW'(devStat);
      ADR_DEV_EN:   rdMux = DataW'(devEnQ);
      ADR_GIE:      rdMux = DataW'(gieQ);
      ADR_IP_STAT:  rdMux = ipStatQ;
      ADR_IP_EN:    rdMux = ipEnQ;
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else     busRdata <= strobe.rdEn ? rdMux : '0;
  end

  logic unusedInputs;
  assign unusedInputs = ^{busWdata, ipEvent, ipResetVal, devLevel};

endmodule

// File: rtl/irq_hier_regs.sv
module irq_hier_regs
  import irq_pkg::*;
#(
  parameter int AddrW    = 3,
  parameter int DataW    = 32,
  parameter int IpWidth  = 12,
  parameter int DevWidth = 4,
  parameter int IpDevBit = 0,
  parameter logic [3:0] RstKey = 4'hA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [DataW-1:0]    busWdata,
  output logic [DataW-1:0]    busRdata,
  input  logic [DataW-1:0]    ipEvent,
  input  logic [DataW-1:0]    ipResetVal,
  input  logic [DevWidth-1:0] devLevel,
  output logic                irq
);

  localparam int KeyW = 4;

  ctrlStrobeT          strobe;
  logic [DataW-1:0]    ipStatQ;
  logic [DataW-1:0]    ipEnQ;
  logic [DevWidth-1:0] devEnQ;
  logic                gieQ;

  irq_ctrl #(
    .AddrW (AddrW),
    .KeyW  (KeyW),
    .RstKey(RstKey)
  ) u_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .keyNibble(busWdata[KeyW-1:0]),
    .strobe   (strobe)
  );

  irq_dpath #(
    .DataW   (DataW),
    .IpWidth (IpWidth),
    .DevWidth(DevWidth),
    .IpDevBit(IpDevBit)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .ipEvent   (ipEvent),
    .ipResetVal(ipResetVal),
    .devLevel  (devLevel),
    .busRdata  (busRdata),
    .ipStatQ   (ipStatQ),
    .ipEnQ     (ipEnQ),
    .devEnQ    (devEnQ),
    .gieQ      (gieQ),
    .irq       (irq)
  );

endmodule

// File: rtl/irq_hier_regs_chk.sv
module irq_hier_regs_chk #(
  parameter int AddrW    = 3,
  parameter int DataW    = 32,
  parameter int IpWidth  = 12,
  parameter int DevWidth = 4,
  parameter int IpDevBit = 0,
  parameter logic [3:0] RstKey = 4'hA
) (
  input logic                clk,
  input logic                rst,
  input logic                busSel,
  input logic                busWr,
  input logic [AddrW-1:0]    busAddr,
  input logic [DataW-1:0]    busWdata,
  input logic [DataW-1:0]    busRdata,
  input logic [DataW-1:0]    ipEvent,
  input logic [DataW-1:0]    ipResetVal,
  input logic [DevWidth-1:0] devLevel,
  input logic                irq,
  input logic [DataW-1:0]    ipStatQ,
  input logic [DataW-1:0]    ipEnQ,
  input logic [DevWidth-1:0] devEnQ,
  input logic                gieQ
);

  localparam logic [DataW-1:0] ImplMask =
    (IpWidth == 0) ? '0 : ({DataW{1'b1}} >> (DataW - IpWidth));

  logic softWr, statWr, rdIpStat, anyRead;
  logic [DevWidth-1:0] devModel;
  assign softWr   = busSel && busWr && (busAddr == AddrW'(3)) && (busWdata[3:0] == RstKey);
  assign statWr   = busSel && busWr && (busAddr == AddrW'(4));
  assign rdIpStat = busSel && !busWr && (busAddr == AddrW'(4));
  assign anyRead  = busSel && !busWr;

  always_comb begin
    devModel = devLevel;
    devModel[IpDevBit] = |(ipStatQ & ipEnQ);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ipEnQ == '0 && devEnQ == '0 && !gieQ &&
             ipStatQ == ($past(ipResetVal) & ImplMask)));

  p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (statWr && ipEvent == '0) |=>
      ipStatQ == ($past(ipStatQ) ^ ($past(busWdata) & ImplMask)));

  p_unimpl_read_r4: assert property (@(posedge clk) disable iff (rst)
    rdIpStat |=> ((busRdata & ~ImplMask) == '0));

  p_event_set_r6: assert property (@(posedge clk) disable iff (rst)
    ((ipEvent & ImplMask) != '0 && !softWr) |=>
      ((ipStatQ & $past(ipEvent & ImplMask)) == $past(ipEvent & ImplMask)));

  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (gieQ && ((devModel & devEnQ) != '0)));

  p_soft_rst_r10: assert property (@(posedge clk) disable iff (rst)
    softWr |=> (!gieQ && ipEnQ == '0 && devEnQ == '0));

  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !anyRead |=> busRdata == '0);

endmodule

bind irq_hier_regs irq_hier_regs_chk #(
  .AddrW(AddrW), .DataW(DataW), .IpWidth(IpWidth),
  .DevWidth(DevWidth), .IpDevBit(IpDevBit), .RstKey(RstKey)
) u_chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .ipEvent(ipEvent),
  .ipResetVal(ipResetVal), .devLevel(devLevel), .irq(irq),
  .ipStatQ(ipStatQ), .ipEnQ(ipEnQ), .devEnQ(devEnQ), .gieQ(gieQ)
);

// File: tb/test_irq_hier_regs.sv
module test_irq_hier_regs;

  localparam int AddrW = 3;
  localparam int DataW = 32;
  localparam int DevW  = 4;

  localparam logic [2:0] A_DSTAT = 3'd0, A_DEN = 3'd1, A_GIE = 3'd2,
                         A_RST = 3'd3, A_ISTAT = 3'd4, A_IEN = 3'd5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             busSel = 1'b0, busWr = 1'b0;
  logic [AddrW-1:0] busAddr = '0;
  logic [DataW-1:0] busWdata = '0;
  logic [DataW-1:0] busRdata;
  logic [DataW-1:0] ipEvent = '0;
  logic [DataW-1:0] ipResetVal = 32'hF000_0081;
  logic [DevW-1:0]  devLevel = '0;
  logic             irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_hier_regs i_irq_hier_regs (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ipEvent(ipEvent),
    .ipResetVal(ipResetVal), .devLevel(devLevel), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    d = busRdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    busRead(A_ISTAT, v); check("R1 ip status reset", v, 32'h081);
    busRead(A_IEN, v);   check("R1 ip enable reset", v, 0);
    busRead(A_DEN, v);   check("R1 dev enable reset", v, 0);
    busRead(A_GIE, v);   check("R1 global enable reset", v, 0);
    busRead(A_DSTAT, v); check("R7 dev status idle", v, 0);
    check("R8 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_toggle;
    logic [31:0] v;
    busWrite(A_ISTAT, 32'h0000_0F06);
    busRead(A_ISTAT, v); check("R2 toggle mix", v, 32'hF87);
    busWrite(A_ISTAT, 32'hFFFF_F000);
    busRead(A_ISTAT, v); check("R4 upper status write ignored", v, 32'hF87);
    busWrite(A_ISTAT, 32'h0000_0F87);
    busRead(A_ISTAT, v); check("R2 toggle clears", v, 0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    busWrite(A_IEN, 32'hFFFF_FFFF);
    busRead(A_IEN, v); check("R4 enable limited to width", v, 32'hFFF);
    busWrite(A_IEN, 32'h0000_05A5);
    busRead(A_IEN, v); check("R3 enable readback", v, 32'h5A5);
    busWrite(A_IEN, 0);
    busRead(A_IEN, v); check("R3 enable cleared", v, 0);
  endtask

  task automatic t_event;
    logic [31:0] v;
    @(negedge clk); ipEvent = 32'h8000_0010;
    @(negedge clk); ipEvent = '0;
    busRead(A_ISTAT, v); check("R5 event latched, R4 upper ignored", v, 32'h010);
    repeat (3) @(negedge clk);
    busRead(A_ISTAT, v); check("R5 event held", v, 32'h010);
    busWrite(A_ISTAT, 32'h010);
    busRead(A_ISTAT, v); check("R5 event acknowledged", v, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    busWrite(A_ISTAT, 32'h040);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = A_ISTAT; busWdata = 32'h040; ipEvent = 32'h040;
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = '0; ipEvent = '0;
    busRead(A_ISTAT, v); check("R6 event wins over ack", v, 32'h040);
    busWrite(A_ISTAT, 32'h040);
    busRead(A_ISTAT, v); check("R6 later ack clears", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    busWrite(A_ISTAT, 32'h200);
    busWrite(A_IEN, 32'h200);
    busRead(A_DSTAT, v); check("R7 ip aggregate in bit 0", v, 32'h1);
    check("R8 irq gated off", {31'b0, irq}, 0);
    busWrite(A_DEN, 32'h1);
    check("R8 irq still gated by global", {31'b0, irq}, 0);
    busWrite(A_GIE, 32'h1);
    check("R8 irq asserted", {31'b0, irq}, 1);
    busRead(A_GIE, v); check("R9 global enable readback", v, 1);
    devLevel = 4'b1010;
    busRead(A_DSTAT, v); check("R7 level bits", v, 32'hB);
    busWrite(A_IEN, 0);
    devLevel = 4'b0001;
    busRead(A_DSTAT, v); check("R7 level on ip bit ignored", v, 0);
    check("R8 irq drops", {31'b0, irq}, 0);
    busWrite(A_DSTAT, 32'hF);
    busRead(A_DSTAT, v); check("R7 dev status write ignored", v, 0);
    busWrite(A_DEN, 32'h2);
    devLevel = 4'b0010;
    #1 check("R8 irq from level source", {31'b0, irq}, 1);
    devLevel = 4'b0000;
    #1 check("R8 irq follows level", {31'b0, irq}, 0);
  endtask

  task automatic t_softrst;
    logic [31:0] v;
    busWrite(A_IEN, 32'h00F);
    busWrite(A_DEN, 32'hF);
    busWrite(A_RST, 32'h5);
    busRead(A_GIE, v); check("R10 wrong key ignored", v, 1);
    busRead(A_IEN, v); check("R10 wrong key keeps enable", v, 32'h00F);
    busWrite(A_RST, 32'hA);
    busRead(A_GIE, v);   check("R10 global enable cleared", v, 0);
    busRead(A_IEN, v);   check("R10 ip enable cleared", v, 0);
    busRead(A_DEN, v);   check("R10 dev enable cleared", v, 0);
    busRead(A_ISTAT, v); check("R10 ip status reloaded", v, 32'h081);
  endtask

  task automatic t_read;
    logic [31:0] v;
    busRead(A_RST, v);   check("R11 reset reg reads 0", v, 0);
    busRead(3'd7, v);    check("R11 unmapped reads 0", v, 0);
    busRead(A_ISTAT, v); check("R11 read one cycle later", v, 32'h081);
    @(negedge clk);
    check("R11 idle rdata 0", busRdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_toggle();
    t_enable();
    t_event();
    t_collide();
    t_irq();
    t_softrst();
    t_read();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule